// File: doc/BRIEF.md
# Auto-Retry Frame Transmit Controller

This block sequences one complete outgoing frame transaction for a low-rate 2.4 GHz wireless MAC. A transaction can be started by a hardware strobe or by a software command. For each attempt the block first asks an external channel-access unit for a verdict. A busy verdict makes it ask again, up to a configured limit. On a clear verdict it hands the buffered frame to the transmitter.

The block reads the acknowledgement-request flag from the first octet of the frame. When that flag is set, the block enables the receiver and waits a fixed number of symbol ticks for an acknowledgement. The acknowledgement must carry the sequence number taken from the third octet of the frame. A timeout or a mismatching acknowledgement starts the whole attempt again, channel access included, until the configured frame-retry limit is used up.

Completion is marked by a one-cycle interrupt and a 3-bit result code. Both retry counters can be read while the transaction runs. The limits and the two frame octets are captured at start, so the frame buffer and the configuration are treated as frozen for the whole transaction.

Top module: `aret_ctrl`

## Requirements
- R1: After reset the block is idle: status_o is 7, irq_o is 0, cca_req_o, tx_req_o and rx_on_o are 0, and both retry counters read 0.
- R2: A pulse on start_hw_i or start_sw_i while idle begins a transaction: cca_req_o rises on the next cycle and status_o reads 7 while the transaction runs. A start pulse during a running transaction has no effect.
- R3: The two retry limits, bit 5 of fc_octet_i and seq_octet_i are sampled only on the start cycle. Changes to them during a transaction do not alter its outcome.
- R4: A busy verdict (cca_done_i with cca_clear_i low) increments cca_retry_o and requests channel access again. Once cca_retry_o equals the channel-access limit, a further busy verdict ends the transaction with status 3.
- R5: A clear verdict raises tx_req_o. If bit 5 of the captured first octet is 0, tx_done_i ends the transaction with status 0, and rx_on_o never rises.
- R6: If bit 5 of the captured first octet is 1, tx_done_i raises rx_on_o. The 54th sym_tick_i received without a valid acknowledgement ends the wait, and the 53rd does not.
- R7: A valid acknowledgement ends the transaction with status 1 if rx_pend_i is 1 and status 0 otherwise. A valid acknowledgement is an rx_valid_i pulse with rx_type_i equal to 3'b010, rx_crc_ok_i equal to 1 and rx_seq_i equal to the captured third octet.
- R8: A received frame whose type is not 3'b010, or whose CRC flag is 0, is ignored, and the wait continues. An acknowledgement-typed frame with a good CRC but a different sequence number counts as a failed attempt.
- R9: A failed attempt (timeout or mismatching acknowledgement) increments frame_retry_o, resets cca_retry_o to 0 and requests channel access again. Once frame_retry_o equals the frame limit, a failed attempt ends the transaction with status 5.
- R10: Completion raises irq_o for exactly one cycle. The result code is valid in that cycle and holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_hw_i | input | 1 | Hardware start strobe |
| start_sw_i | input | 1 | Software transmit-start command pulse |
| cfg_cca_max_i | input | CCA_W | Maximum channel-access retries |
| cfg_frm_max_i | input | FRM_W | Maximum frame retries |
| fc_octet_i | input | 8 | First PSDU octet; bit 5 is the acknowledgement request |
| seq_octet_i | input | SEQ_W | Third PSDU octet (sequence number) |
| cca_req_o | output | 1 | Channel-access verdict request (level) |
| cca_done_i | input | 1 | Verdict strobe |
| cca_clear_i | input | 1 | Verdict: 1 means clear, 0 means busy |
| tx_req_o | output | 1 | Send buffered frame (level) |
| tx_done_i | input | 1 | Transmission finished strobe |
| rx_on_o | output | 1 | Receiver enabled for acknowledgement wait |
| rx_valid_i | input | 1 | Received-frame descriptor strobe |
| rx_type_i | input | TYPE_W | Received frame type |
| rx_crc_ok_i | input | 1 | Received frame CRC good |
| rx_seq_i | input | SEQ_W | Received sequence number |
| rx_pend_i | input | 1 | Received frame-pending flag |
| sym_tick_i | input | 1 | One pulse per symbol period |
| status_o | output | 3 | Result: 0 ok, 1 ok with pending, 3 channel fail, 5 no ack, 7 idle or running |
| cca_retry_o | output | CCA_W | Live channel-access retry count |
| frame_retry_o | output | FRM_W | Live frame retry count |
| irq_o | output | 1 | Transaction-end pulse |

## Verification
The assertions assume that the channel-access unit and the transmitter raise their done strobes only while their own request is high, and that each strobe is a single-cycle pulse. They also assume that descriptors and symbol ticks matter only while rx_on_o is high. The bench respects this by reacting to the request levels one cycle at a time and by deasserting every strobe after one cycle. The deliberate misuse it does apply is limited to the cases the requirements address: start pulses during a run, configuration changes in mid-transaction and non-matching frames.

// File: rtl/aret_pkg.sv
package aret_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CCA, ST_TX, ST_ACK} aret_state_e;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_OK_PEND  = 3'd1,
    RES_CCA_FAIL = 3'd3,
    RES_NO_ACK   = 3'd5,
    RES_IDLE     = 3'd7
  } aret_res_e;

  localparam int          ACK_REQ_BIT = 5;
  localparam logic [2:0]  FTYPE_ACK   = 3'b010;
endpackage

// File: rtl/aret_retry_cnt.sv
module aret_retry_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == max_i);

  // R4 / R9: the sequencer never steps a counter beyond its limit
  p_no_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !at_max_o);
endmodule

// File: rtl/aret_sym_timer.sv
module aret_sym_timer #(
  parameter int LIMIT = 54
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && tick_i && (cnt_q == CW'(LIMIT - 1));

  p_wait_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < CW'(LIMIT)));
endmodule

// File: rtl/aret_ack_match.sv
module aret_ack_match #(
  parameter int TYPE_W = 3,
  parameter int SEQ_W  = 8
) (
  input  logic              rx_valid_i,
  input  logic [TYPE_W-1:0] rx_type_i,
  input  logic              rx_crc_ok_i,
  input  logic [SEQ_W-1:0]  rx_seq_i,
  input  logic [SEQ_W-1:0]  exp_seq_i,
  output logic              ack_ok_o,
  output logic              ack_bad_o
);
  import aret_pkg::*;

  logic is_ack;

  // frames of another type or with a bad CRC are neither ok nor bad: dropped
  assign is_ack    = rx_valid_i && rx_crc_ok_i && (rx_type_i == TYPE_W'(FTYPE_ACK));
  assign ack_ok_o  = is_ack && (rx_seq_i == exp_seq_i);
  assign ack_bad_o = is_ack && (rx_seq_i != exp_seq_i);
endmodule

// File: rtl/aret_ctrl.sv
module aret_ctrl #(
  parameter int CCA_W         = 3,
  parameter int FRM_W         = 4,
  parameter int ACK_WAIT_SYMS = 54,
  parameter int TYPE_W        = 3,
  parameter int SEQ_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_hw_i,
  input  logic              start_sw_i,
  input  logic [CCA_W-1:0]  cfg_cca_max_i,
  input  logic [FRM_W-1:0]  cfg_frm_max_i,
  input  logic [7:0]        fc_octet_i,
  input  logic [SEQ_W-1:0]  seq_octet_i,
  output logic              cca_req_o,
  input  logic              cca_done_i,
  input  logic              cca_clear_i,
  output logic              tx_req_o,
  input  logic              tx_done_i,
  output logic              rx_on_o,
  input  logic              rx_valid_i,
  input  logic [TYPE_W-1:0] rx_type_i,
  input  logic              rx_crc_ok_i,
  input  logic [SEQ_W-1:0]  rx_seq_i,
  input  logic              rx_pend_i,
  input  logic              sym_tick_i,
  output logic [2:0]        status_o,
  output logic [CCA_W-1:0]  cca_retry_o,
  output logic [FRM_W-1:0]  frame_retry_o,
  output logic              irq_o
);
  import aret_pkg::*;

  aret_state_e      state_q, state_d;
  logic [CCA_W-1:0] cca_max_q;
  logic [FRM_W-1:0] frm_max_q;
  logic [SEQ_W-1:0] seq_q;
  logic             ack_req_q;
  logic [2:0]       status_q;
  logic             irq_q;

  logic       start;
  logic       cca_clr, cca_inc, cca_at_max;
  logic       frm_clr, frm_inc, frm_at_max;
  logic       tmr_clr, tmr_expire;
  logic       ack_ok, ack_bad;
  logic       done;
  aret_res_e  done_code;

  assign start = start_hw_i || start_sw_i;

  aret_retry_cnt #(.W(CCA_W)) i_cca_cnt (
    .clk_i, .rst_ni, .clr_i(cca_clr), .inc_i(cca_inc),
    .max_i(cca_max_q), .cnt_o(cca_retry_o), .at_max_o(cca_at_max)
  );

  aret_retry_cnt #(.W(FRM_W)) i_frm_cnt (
    .clk_i, .rst_ni, .clr_i(frm_clr), .inc_i(frm_inc),
    .max_i(frm_max_q), .cnt_o(frame_retry_o), .at_max_o(frm_at_max)
  );

  aret_sym_timer #(.LIMIT(ACK_WAIT_SYMS)) i_timer (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .en_i(state_q == ST_ACK),
    .tick_i(sym_tick_i), .expire_o(tmr_expire)
  );

  aret_ack_match #(.TYPE_W(TYPE_W), .SEQ_W(SEQ_W)) i_ack (
    .rx_valid_i, .rx_type_i, .rx_crc_ok_i, .rx_seq_i,
    .exp_seq_i(seq_q), .ack_ok_o(ack_ok), .ack_bad_o(ack_bad)
  );

  always_comb begin
    state_d   = state_q;
    cca_clr   = 1'b0;
    cca_inc   = 1'b0;
    frm_clr   = 1'b0;
    frm_inc   = 1'b0;
    tmr_clr   = 1'b0;
    done      = 1'b0;
    done_code = RES_IDLE;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_CCA;
        cca_clr = 1'b1;
        frm_clr = 1'b1;
      end
      ST_CCA: if (cca_done_i) begin
        if (cca_clear_i)     state_d = ST_TX;
        else if (cca_at_max) begin done = 1'b1; done_code = RES_CCA_FAIL; end
        else                 cca_inc = 1'b1;
      end
      ST_TX: if (tx_done_i) begin
        if (ack_req_q) begin state_d = ST_ACK; tmr_clr = 1'b1; end
        else           begin done = 1'b1; done_code = RES_OK; end
      end
      ST_ACK: begin
        if (ack_ok) begin
          done      = 1'b1;
          done_code = rx_pend_i ? RES_OK_PEND : RES_OK;
        end else if (ack_bad || tmr_expire) begin
          if (frm_at_max) begin
            done      = 1'b1;
            done_code = RES_NO_ACK;
          end else begin
            frm_inc = 1'b1;
            cca_clr = 1'b1;
            state_d = ST_CCA;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (done) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cca_max_q <= '0;
      frm_max_q <= '0;
      seq_q     <= '0;
      ack_req_q <= 1'b0;
      status_q  <= RES_IDLE;
      irq_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= done;
      if (state_q == ST_IDLE && start) begin
        cca_max_q <= cfg_cca_max_i;
        frm_max_q <= cfg_frm_max_i;
        seq_q     <= seq_octet_i;
        ack_req_q <= fc_octet_i[ACK_REQ_BIT];
        status_q  <= RES_IDLE;
      end else if (done) begin
        status_q  <= done_code;
      end
    end
  end

  assign cca_req_o = (state_q == ST_CCA);
  assign tx_req_o  = (state_q == ST_TX);
  assign rx_on_o   = (state_q == ST_ACK);
  assign status_o  = status_q;
  assign irq_o     = irq_q;

  p_irq_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != RES_IDLE));

  p_run_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cca_req_o || tx_req_o || rx_on_o) |-> (status_o == RES_IDLE));

  p_busy_retry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cca_req_o && cca_done_i && !cca_clear_i && !cca_at_max)
      |=> (cca_req_o && cca_retry_o == $past(cca_retry_o) + 1'b1));

  p_attempt_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cca_req_o) |-> (cca_retry_o == '0));

  p_ack_wait_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_on_o) |-> ack_req_q);
endmodule

// File: tb/test_aret_ctrl.sv
`timescale 1ns/1ps
module test_aret_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_hw_i = 0, start_sw_i = 0;
  logic [2:0] cfg_cca_max_i = 0;
  logic [3:0] cfg_frm_max_i = 0;
  logic [7:0] fc_octet_i = 0, seq_octet_i = 0;
  logic       cca_done_i = 0, cca_clear_i = 0, tx_done_i = 0;
  logic       rx_valid_i = 0, rx_crc_ok_i = 0, rx_pend_i = 0, sym_tick_i = 0;
  logic [2:0] rx_type_i = 0;
  logic [7:0] rx_seq_i = 0;
  logic       cca_req_o, tx_req_o, rx_on_o, irq_o;
  logic [2:0] status_o, cca_retry_o;
  logic [3:0] frame_retry_o;

  int checks = 0, errors = 0;
  bit fin = 0;

  always #2 clk_i = ~clk_i;

  aret_ctrl i_aret_ctrl (.*);

  typedef struct packed {
    logic [2:0] mc;   logic [3:0] mf;  logic [3:0] busy; logic ack;
    logic [3:0] fails; logic pend;     logic [2:0] st;   logic [3:0] frm;
    logic [2:0] cca;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd4, 4'd3,  4'd0, 1'b0, 4'd0, 1'b0, 3'd0, 4'd0, 3'd0},  // R5
    '{3'd4, 4'd3,  4'd2, 1'b1, 4'd0, 1'b0, 3'd0, 4'd0, 3'd2},  // R4 R7
    '{3'd4, 4'd3,  4'd1, 1'b1, 4'd0, 1'b1, 3'd1, 4'd0, 3'd1},  // R7 pending
    '{3'd2, 4'd3,  4'd3, 1'b1, 4'd0, 1'b0, 3'd3, 4'd0, 3'd2},  // R4 abort
    '{3'd0, 4'd3,  4'd1, 1'b1, 4'd0, 1'b0, 3'd3, 4'd0, 3'd0},  // R4 limit 0
    '{3'd4, 4'd3,  4'd0, 1'b1, 4'd2, 1'b0, 3'd0, 4'd2, 3'd0},  // R6 R9
    '{3'd4, 4'd2,  4'd1, 1'b1, 4'd3, 1'b0, 3'd5, 4'd2, 3'd1},  // R9 no ack
    '{3'd4, 4'd0,  4'd0, 1'b1, 4'd1, 1'b0, 3'd5, 4'd0, 3'd0},  // R9 limit 0
    '{3'd7, 4'd15, 4'd7, 1'b0, 4'd0, 1'b0, 3'd0, 4'd0, 3'd7},  // R4 max busy
    '{3'd4, 4'd3,  4'd2, 1'b1, 4'd1, 1'b1, 3'd1, 4'd1, 3'd2}   // R9 restart
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic sw);
    if (sw) start_sw_i = 1; else start_hw_i = 1;
    @(negedge clk_i);
    start_sw_i = 0; start_hw_i = 0;
  endtask

  task automatic pulse_cca(input logic clear);
    cca_done_i = 1; cca_clear_i = clear;
    @(negedge clk_i);
    cca_done_i = 0; cca_clear_i = 0;
  endtask

  task automatic pulse_tx();
    tx_done_i = 1;
    @(negedge clk_i);
    tx_done_i = 0;
  endtask

  task automatic pulse_tick();
    sym_tick_i = 1;
    @(negedge clk_i);
    sym_tick_i = 0;
  endtask

  task automatic pulse_rx(input logic [2:0] ty, input logic crc,
                          input logic [7:0] sq, input logic pd);
    rx_valid_i = 1; rx_type_i = ty; rx_crc_ok_i = crc; rx_seq_i = sq; rx_pend_i = pd;
    @(negedge clk_i);
    rx_valid_i = 0; rx_crc_ok_i = 0; rx_pend_i = 0;
  endtask

  // reactive responder for one vector; returns when irq_o is seen
  task automatic run_vec(input vec_t v, input logic [7:0] sq, input logic sw,
                         output logic got);
    logic [3:0] bl = v.busy;
    int attempt = 0;
    cfg_cca_max_i = v.mc; cfg_frm_max_i = v.mf;
    fc_octet_i = v.ack ? 8'h21 : 8'h01; seq_octet_i = sq;
    got = 0;
    pulse_start(sw);
    for (int n = 0; n < 4000 && !got; n++) begin
      if (irq_o) got = 1;
      else if (cca_req_o) begin
        pulse_cca(bl == 0);
        if (bl != 0) bl--;
      end else if (tx_req_o) begin
        bl = v.busy; attempt++;
        pulse_tx();
      end else if (rx_on_o) begin
        if (attempt <= int'(v.fails)) pulse_tick();
        else pulse_rx(3'b010, 1'b1, sq, v.pend);
      end else @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    logic got;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 status", status_o, 7);
    chk("R1 irq", irq_o, 0);
    chk("R1 requests", {cca_req_o, tx_req_o, rx_on_o}, 0);
    chk("R1 counters", {cca_retry_o, frame_retry_o}, 0);

    foreach (VEC[i]) begin
      run_vec(VEC[i], 8'h40 + 8'(i), i[0], got);
      chk($sformatf("R10 vec%0d irq", i), got, 1);
      chk($sformatf("R4/R5/R7/R9 vec%0d status", i), status_o, VEC[i].st);
      chk($sformatf("R9 vec%0d frame_retry", i), frame_retry_o, VEC[i].frm);
      chk($sformatf("R4 vec%0d cca_retry", i), cca_retry_o, VEC[i].cca);
      @(negedge clk_i);
      chk($sformatf("R10 vec%0d irq drops", i), irq_o, 0);
      chk($sformatf("R10 vec%0d status held", i), status_o, VEC[i].st);
    end

    // R2: start, running status, stray start ignored
    cfg_cca_max_i = 3; cfg_frm_max_i = 2; fc_octet_i = 8'h01; seq_octet_i = 8'h11;
    pulse_start(1'b0);
    chk("R2 cca_req after start", cca_req_o, 1);
    chk("R2 status running", status_o, 7);
    pulse_start(1'b1);
    pulse_cca(1'b1);
    pulse_start(1'b0);
    chk("R2 tx_req", tx_req_o, 1);
    pulse_tx();
    chk("R5 no-ack done", {irq_o, status_o}, {1'b1, 3'd0});
    chk("R5 rx_on stays low", rx_on_o, 0);
    repeat (2) @(negedge clk_i);
    chk("R2 stray start ignored", {cca_req_o, tx_req_o, rx_on_o, irq_o}, 0);

    // R3: limit changed mid-run
    cfg_cca_max_i = 0; fc_octet_i = 8'h01;
    pulse_start(1'b0);
    cfg_cca_max_i = 7; fc_octet_i = 8'h20;
    pulse_cca(1'b0);
    chk("R3 captured cca limit", {irq_o, status_o}, {1'b1, 3'd3});
    // R3: ack-request bit changed mid-run
    cfg_cca_max_i = 7; fc_octet_i = 8'h01;
    pulse_start(1'b1);
    fc_octet_i = 8'h21;
    pulse_cca(1'b1);
    pulse_tx();
    chk("R3 captured ack bit", {irq_o, status_o, rx_on_o}, {1'b1, 3'd0, 1'b0});

    // R8: discarded frames, then mismatching ack
    cfg_cca_max_i = 2; cfg_frm_max_i = 1; fc_octet_i = 8'h20; seq_octet_i = 8'h5A;
    pulse_start(1'b0);
    seq_octet_i = 8'h00;
    pulse_cca(1'b1);
    pulse_tx();
    chk("R6 rx_on after tx", rx_on_o, 1);
    pulse_rx(3'b001, 1'b1, 8'h5A, 1'b0);
    chk("R8 data frame ignored", {rx_on_o, irq_o, cca_req_o}, {1'b1, 1'b0, 1'b0});
    pulse_rx(3'b010, 1'b0, 8'h5A, 1'b0);
    chk("R8 bad crc ignored", {rx_on_o, irq_o, cca_req_o}, {1'b1, 1'b0, 1'b0});
    pulse_rx(3'b010, 1'b1, 8'h5B, 1'b0);
    chk("R8 wrong seq retries", {cca_req_o, irq_o}, {1'b1, 1'b0});
    chk("R9 frame_retry after bad ack", frame_retry_o, 1);
    pulse_cca(1'b1);
    pulse_tx();
    pulse_rx(3'b010, 1'b1, 8'h5A, 1'b1);
    chk("R7 pending after retry", {irq_o, status_o}, {1'b1, 3'd1});

    // R6: exact timeout boundary
    cfg_cca_max_i = 1; cfg_frm_max_i = 1; fc_octet_i = 8'h20; seq_octet_i = 8'h33;
    pulse_start(1'b1);
    pulse_cca(1'b1);
    pulse_tx();
    for (int k = 0; k < 53; k++) pulse_tick();
    chk("R6 still waiting after 53", {rx_on_o, cca_req_o}, {1'b1, 1'b0});
    pulse_tick();
    chk("R6 timeout on 54th", {rx_on_o, cca_req_o}, {1'b0, 1'b1});
    chk("R9 frame_retry after timeout", frame_retry_o, 1);
    pulse_cca(1'b0);
    chk("R4 busy counted", cca_retry_o, 1);
    pulse_cca(1'b1);
    pulse_tx();
    for (int k = 0; k < 54; k++) pulse_tick();
    chk("R9 no-ack at limit", {irq_o, status_o}, {1'b1, 3'd5});

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule